// File: doc/BRIEF.md
# Input Sample-Rate Classifier with Lock Control

This block watches an incoming audio clock and decides which standard sample rate it carries. In PCM mode it measures the frame (word) clock; in DSD mode it measures the one-bit bit clock. Every measurement spans a fixed number of input periods and is counted in cycles of a single fixed 24.576 MHz reference. The total is then compared against a table of accepted rates, each with a ±2 % tolerance band. A match is reported as a 4-bit rate code together with a lock flag.

Lock is declared only when two back-to-back measurement windows give the same rate. Lock is dropped when:

- a window disagrees with the locked rate,
- the input clock stops for longer than a timeout, or
- the active-low data-valid input is high.

An active-low interrupt line falls whenever lock is lost. It rises again only when a rate is reacquired. The downstream data path uses the lock flag to decide whether samples are processed.

Top module: `clk_rate_classifier`

## Requirements
- R1: After reset the rate code is 0000, the lock flag is 0 and the interrupt line is 1.
- R2: With PCM mode selected (`dsd_sel_i` = 0), a word clock within ±2 % of a standard rate locks with these codes: 32 kHz 0001, 44.1 kHz 0010, 48 kHz 0011, 88.2 kHz 0100, 96 kHz 0101, 176.4 kHz 0110, 192 kHz 0111, 352.8 kHz 1000, 384 kHz 1001. The rate code never exceeds 1101.
- R3: With DSD mode selected (`dsd_sel_i` = 1), the bit clock is measured and locks with these codes: 2.8224 MHz 1010, 3.072 MHz 1011, 5.6448 MHz 1100, 6.144 MHz 1101. In this mode the word clock has no effect.
- R4: A clock that is more than 2 % away from every accepted rate of the selected mode leaves the block unlocked with code 0000.
- R5: Lock is set only on the completion of a measurement window whose rate equals that of the window just before it. Whenever the block is unlocked the code is 0000.
- R6: While `data_valid_n_i` is 1, the lock flag is 0 from the next clock on, and no lock is acquired.
- R7: The interrupt line goes to 0 in the same cycle the lock flag falls. It returns to 1 only in the cycle a new lock is set.
- R8: If no edge of the measured clock arrives for `TIMEOUT_CYC` reference cycles, the block unlocks on the following cycle.
- R9: While the lock flag stays 1, the rate code does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wclk_i | input | 1 | PCM word clock, asynchronous |
| bclk_i | input | 1 | DSD bit clock, asynchronous |
| dsd_sel_i | input | 1 | 1 selects DSD measurement, 0 selects PCM |
| data_valid_n_i | input | 1 | Upstream data valid, active low; high blocks lock |
| rate_code_o | output | 4 | Classified rate, 0000 when unlocked |
| locked_o | output | 1 | Lock flag |
| irq_n_o | output | 1 | Interrupt, low after loss of lock until relock |

## Verification
The hardest case to reach is a rate change that lands in the middle of a measurement window. That window then mixes periods of the old and new rate, and it can fall inside either band or inside neither. As a result, the exact cycle of the unlock is not known in advance.

The stimulus handles this by switching the generator period at an arbitrary point and waiting a bound of three new windows. It records whether the interrupt line went low at any moment in between, then checks the settled code.

The bench runs an instance with a shortened window and timeout, so each rate, the tolerance edges and the clock-stop timeout fit in a short run. The DSD rates are generated with whole-cycle periods.

// File: rtl/rate_cls_pkg.sv
package rate_cls_pkg;

   localparam int CODE_W   = 4;
   localparam int NUM_PCM  = 9;
   localparam int NUM_DSD  = 4;
   localparam int DSD_BASE = 10;

   // accepted PCM frame rates in Hz, ascending; index i reports code i+1
   function automatic longint pcm_hz(input int idx);
      case (idx)
         0: return 64'd32000;
         1: return 64'd44100;
         2: return 64'd48000;
         3: return 64'd88200;
         4: return 64'd96000;
         5: return 64'd176400;
         6: return 64'd192000;
         7: return 64'd352800;
         default: return 64'd384000;
      endcase
   endfunction

   // accepted DSD bit rates in Hz; index j reports code DSD_BASE+j
   function automatic longint dsd_hz(input int idx);
      case (idx)
         0: return 64'd2822400;
         1: return 64'd3072000;
         2: return 64'd5644800;
         default: return 64'd6144000;
      endcase
   endfunction

   function automatic longint nominal_count(input longint ref_hz, input longint win,
                                            input longint hz);
      return (ref_hz * win) / hz;
   endfunction

   function automatic longint band_lo(input longint nom, input longint tol_pct);
      return (nom * (100 - tol_pct)) / 100;
   endfunction

   function automatic longint band_hi(input longint nom, input longint tol_pct);
      return (nom * (100 + tol_pct)) / 100;
   endfunction

endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/period_meter.sv
module period_meter #(
   parameter int WIN   = 64,
   parameter int CNT_W = 16,
   parameter int TMO   = 24576
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edge_i,
   input  logic             restart_i,
   output logic             done_o,
   output logic [CNT_W-1:0] meas_o,
   output logic             tmo_o
);
   localparam int NE_W = (WIN > 2) ? $clog2(WIN) : 1;
   localparam int ID_W = $clog2(TMO + 1);

   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;
   logic [NE_W-1:0]  nedge_q;
   logic [ID_W-1:0]  idle_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             idle_hit;

   assign cnt_inc  = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
   assign idle_hit = !edge_i && (idle_q == ID_W'(TMO - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
         nedge_q <= '0;
         idle_q  <= '0;
         done_o  <= 1'b0;
         meas_o  <= '0;
         tmo_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         tmo_o  <= idle_hit;
         if (edge_i)
            idle_q <= '0;
         else if (idle_q != ID_W'(TMO))
            idle_q <= idle_q + 1'b1;

         if (restart_i || idle_hit) begin
            armed_q <= 1'b0;
         end else if (edge_i) begin
            if (!armed_q) begin
               armed_q <= 1'b1;
               cnt_q   <= CNT_W'(1);
               nedge_q <= '0;
            end else if (nedge_q == NE_W'(WIN - 1)) begin
               done_o  <= 1'b1;
               meas_o  <= cnt_q;
               cnt_q   <= CNT_W'(1);
               nedge_q <= '0;
            end else begin
               nedge_q <= nedge_q + 1'b1;
               cnt_q   <= cnt_inc;
            end
         end else if (armed_q) begin
            cnt_q <= cnt_inc;
         end
      end
   end
endmodule

// File: rtl/rate_matcher.sv
module rate_matcher
   import rate_cls_pkg::*;
#(
   parameter longint REF_HZ = 24576000,
   parameter int     WIN    = 64,
   parameter int     TOL    = 2,
   parameter int     CNT_W  = 16
) (
   input  logic [CNT_W-1:0]  meas_i,
   input  logic              dsd_i,
   output logic [CODE_W-1:0] code_o
);
   logic [NUM_PCM-1:0] pcm_hit;
   logic [NUM_DSD-1:0] dsd_hit;

   for (genvar i = 0; i < NUM_PCM; i++) begin : g_pcm
      localparam longint NOM = nominal_count(REF_HZ, WIN, pcm_hz(i));
      localparam logic [CNT_W-1:0] LO = CNT_W'(band_lo(NOM, TOL));
      localparam logic [CNT_W-1:0] HI = CNT_W'(band_hi(NOM, TOL));
      assign pcm_hit[i] = (meas_i >= LO) && (meas_i <= HI);
   end

   for (genvar j = 0; j < NUM_DSD; j++) begin : g_dsd
      localparam longint NOM = nominal_count(REF_HZ, WIN, dsd_hz(j));
      localparam logic [CNT_W-1:0] LO = CNT_W'(band_lo(NOM, TOL));
      localparam logic [CNT_W-1:0] HI = CNT_W'(band_hi(NOM, TOL));
      assign dsd_hit[j] = (meas_i >= LO) && (meas_i <= HI);
   end

   always_comb begin
      code_o = '0;
      if (dsd_i) begin
         for (int j = NUM_DSD - 1; j >= 0; j--) begin
            if (dsd_hit[j]) code_o = CODE_W'(DSD_BASE + j);
         end
      end else begin
         for (int i = NUM_PCM - 1; i >= 0; i--) begin
            if (pcm_hit[i]) code_o = CODE_W'(i + 1);
         end
      end
   end
endmodule

// File: rtl/rate_lock_fsm.sv
module rate_lock_fsm
   import rate_cls_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic [CODE_W-1:0] match_i,
   input  logic              tmo_i,
   input  logic              invalid_i,
   output logic              locked_o,
   output logic [CODE_W-1:0] code_o,
   output logic              irq_n_o
);
   logic [CODE_W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q   <= '0;
         locked_o <= 1'b0;
         code_o   <= '0;
         irq_n_o  <= 1'b1;
      end else if (invalid_i || tmo_i) begin
         prev_q   <= '0;
         locked_o <= 1'b0;
         code_o   <= '0;
         if (locked_o) irq_n_o <= 1'b0;
      end else if (done_i) begin
         if (match_i == '0 || (locked_o && match_i != code_o)) begin
            prev_q   <= match_i;
            locked_o <= 1'b0;
            code_o   <= '0;
            if (locked_o) irq_n_o <= 1'b0;
         end else if (!locked_o) begin
            prev_q <= match_i;
            if (match_i == prev_q) begin
               locked_o <= 1'b1;
               code_o   <= match_i;
               irq_n_o  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/clk_rate_classifier.sv
module clk_rate_classifier
   import rate_cls_pkg::*;
#(
   parameter longint REF_HZ      = 24576000,
   parameter int     WIN_PERIODS = 64,
   parameter int     TOL_PCT     = 2,
   parameter int     TIMEOUT_CYC = 24576,
   parameter int     SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wclk_i,
   input  logic              bclk_i,
   input  logic              dsd_sel_i,
   input  logic              data_valid_n_i,
   output logic [CODE_W-1:0] rate_code_o,
   output logic              locked_o,
   output logic              irq_n_o
);
   localparam longint MAX_CNT =
      band_hi(nominal_count(REF_HZ, WIN_PERIODS, pcm_hz(0)), TOL_PCT) + 1;
   localparam int CNT_W = $clog2(MAX_CNT + 1);

   if (WIN_PERIODS < 2 || (WIN_PERIODS & (WIN_PERIODS - 1)) != 0) begin : g_bad_win
      $error("WIN_PERIODS must be a power of two of at least 2");
   end
   if (TOL_PCT < 1 || TOL_PCT > 20) begin : g_bad_tol
      $error("TOL_PCT must lie in 1..20");
   end
   if (TIMEOUT_CYC < 4) begin : g_bad_tmo
      $error("TIMEOUT_CYC must be at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [1:0]        raw_clk;
   logic [1:0]        rise;
   logic              dsd_q;
   logic              sel_edge;
   logic              restart;
   logic              win_done;
   logic              tmo_pulse;
   logic [CNT_W-1:0]  win_meas;
   logic [CODE_W-1:0] match_code;

   assign raw_clk = {bclk_i, wclk_i};

   for (genvar k = 0; k < 2; k++) begin : g_sync
      edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (raw_clk[k]),
         .rise_o  (rise[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dsd_q <= 1'b0;
      else        dsd_q <= dsd_sel_i;
   end

   assign sel_edge = dsd_sel_i ? rise[1] : rise[0];
   assign restart  = data_valid_n_i | (dsd_sel_i ^ dsd_q);

   period_meter #(.WIN(WIN_PERIODS), .CNT_W(CNT_W), .TMO(TIMEOUT_CYC)) u_meter (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_i    (sel_edge),
      .restart_i (restart),
      .done_o    (win_done),
      .meas_o    (win_meas),
      .tmo_o     (tmo_pulse)
   );

   rate_matcher #(.REF_HZ(REF_HZ), .WIN(WIN_PERIODS), .TOL(TOL_PCT), .CNT_W(CNT_W)) u_match (
      .meas_i (win_meas),
      .dsd_i  (dsd_sel_i),
      .code_o (match_code)
   );

   rate_lock_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_i    (win_done),
      .match_i   (match_code),
      .tmo_i     (tmo_pulse),
      .invalid_i (data_valid_n_i),
      .locked_o  (locked_o),
      .code_o    (rate_code_o),
      .irq_n_o   (irq_n_o)
   );
endmodule

// File: rtl/clk_rate_classifier_chk.sv
module clk_rate_classifier_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       data_valid_n,
   input logic       locked,
   input logic       irq_n,
   input logic [3:0] rate_code,
   input logic       win_done,
   input logic       tmo
);
   p_code_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rate_code <= 4'd13);

   p_unlocked_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |-> rate_code == 4'd0);

   p_lock_on_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(win_done));

   p_invalid_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      data_valid_n |=> !locked);

   p_irq_on_loss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> !irq_n);

   p_irq_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_n) |-> locked);

   p_timeout_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo |=> !locked);

   p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      locked && $past(locked) |-> $stable(rate_code));
endmodule

bind clk_rate_classifier clk_rate_classifier_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .data_valid_n (data_valid_n_i),
   .locked       (locked_o),
   .irq_n        (irq_n_o),
   .rate_code    (rate_code_o),
   .win_done     (win_done),
   .tmo          (tmo_pulse)
);

// File: tb/sim_clk_rate_classifier.sv
`timescale 1ns/1ps
module sim_clk_rate_classifier;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wclk = 1'b0;
   logic       bclk = 1'b0;
   logic       dsd_sel = 1'b0;
   logic       valid_n = 1'b0;
   logic [3:0] rate_code;
   logic       locked;
   logic       irq_n;

   int  checks = 0;
   int  fails = 0;
   int  w_per = 0;
   int  b_per = 0;
   bit  irq_low_seen = 1'b0;
   bit  reported = 1'b0;

   logic [5:0] exp_q[$];
   string      tag_q[$];
   logic [5:0] exp_item;
   string      exp_tag;

   always #10 clk = ~clk;

   clk_rate_classifier #(.WIN_PERIODS(8), .TIMEOUT_CYC(2000)) u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .wclk_i         (wclk),
      .bclk_i         (bclk),
      .dsd_sel_i      (dsd_sel),
      .data_valid_n_i (valid_n),
      .rate_code_o    (rate_code),
      .locked_o       (locked),
      .irq_n_o        (irq_n)
   );

   // measured clock generators, periods in reference cycles (0 = stopped)
   initial forever begin
      if (w_per < 2) begin
         wclk = 1'b0;
         @(negedge clk);
      end else begin
         wclk = 1'b1;
         repeat (w_per / 2) @(negedge clk);
         wclk = 1'b0;
         repeat (w_per - w_per / 2) @(negedge clk);
      end
   end

   initial forever begin
      if (b_per < 2) begin
         bclk = 1'b0;
         @(negedge clk);
      end else begin
         bclk = 1'b1;
         repeat (b_per / 2) @(negedge clk);
         bclk = 1'b0;
         repeat (b_per - b_per / 2) @(negedge clk);
      end
   end

   // monitor: pops expected items and compares them away from the active edge
   always @(negedge clk) begin
      if (!irq_n) irq_low_seen = 1'b1;
      if (exp_q.size() > 0) begin
         exp_item = exp_q.pop_front();
         exp_tag  = tag_q.pop_front();
         checks++;
         if ({rate_code, locked, irq_n} !== exp_item) begin
            fails++;
            $display("FAIL %s: code=%b locked=%b irq_n=%b, expected code=%b locked=%b irq_n=%b",
                     exp_tag, rate_code, locked, irq_n,
                     exp_item[5:2], exp_item[1], exp_item[0]);
         end
      end
   end

   task automatic expect_out(input string tag, input logic [3:0] code,
                             input logic lk, input logic irq);
      @(posedge clk);
      exp_q.push_back({code, lk, irq});
      tag_q.push_back(tag);
      @(negedge clk);
      #1;
   endtask

   task automatic expect_seen(input string tag, input bit actual, input bit expected);
      checks++;
      if (actual !== expected) begin
         fails++;
         $display("FAIL %s: flag=%0b, expected %0b", tag, actual, expected);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run still active, expected completion");
      report();
   end

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      expect_out("R1 reset state", 4'd0, 1'b0, 1'b1);

      // R5: one window is not enough to lock; 48 kHz = 512 ref cycles
      w_per = 512;
      wait_cyc(6600);
      expect_out("R5 single window no lock", 4'd0, 1'b0, 1'b1);
      wait_cyc(3400);
      expect_out("R2 48k lock", 4'd3, 1'b1, 1'b1);

      // R2/R7: rate change to 96 kHz mid-window
      irq_low_seen = 1'b0;
      w_per = 256;
      wait_cyc(9000);
      expect_out("R2 96k lock after change", 4'd5, 1'b1, 1'b1);
      expect_seen("R7 irq low during rate change", irq_low_seen, 1'b1);

      w_per = 64;
      wait_cyc(4000);
      expect_out("R2 384k lock", 4'd9, 1'b1, 1'b1);

      w_per = 768;
      wait_cyc(19500);
      expect_out("R2 32k lock", 4'd1, 1'b1, 1'b1);

      // tolerance edges around 48 kHz: 520 is -1.5 %, 530 is -3.4 %
      w_per = 520;
      wait_cyc(13300);
      expect_out("R2 48k at -1.5% locks", 4'd3, 1'b1, 1'b1);

      w_per = 530;
      wait_cyc(13500);
      expect_out("R4 off-band clock unlocked", 4'd0, 1'b0, 1'b0);

      // R6: invalid data blocks lock on a good clock
      valid_n = 1'b1;
      w_per = 512;
      wait_cyc(13000);
      expect_out("R6 no lock while invalid", 4'd0, 1'b0, 1'b0);
      valid_n = 1'b0;
      wait_cyc(13000);
      expect_out("R7 relock releases irq", 4'd3, 1'b1, 1'b1);
      valid_n = 1'b1;
      expect_out("R6 invalid drops lock next cycle", 4'd0, 1'b0, 1'b0);
      valid_n = 1'b0;
      wait_cyc(13000);
      expect_out("R2 48k relock", 4'd3, 1'b1, 1'b1);

      // R8: clock stops
      w_per = 0;
      wait_cyc(3000);
      expect_out("R8 timeout unlock", 4'd0, 1'b0, 1'b0);

      // R3: DSD rates with whole-cycle periods
      dsd_sel = 1'b1;
      b_per = 8;
      wait_cyc(2000);
      expect_out("R3 3.072M lock", 4'd11, 1'b1, 1'b1);
      w_per = 256;
      wait_cyc(2000);
      expect_out("R3 word clock ignored in DSD mode", 4'd11, 1'b1, 1'b1);
      w_per = 0;
      b_per = 4;
      wait_cyc(2000);
      expect_out("R3 6.144M lock", 4'd13, 1'b1, 1'b1);
      b_per = 9;
      wait_cyc(2000);
      expect_out("R4 off-band DSD unlocked", 4'd0, 1'b0, 1'b0);

      wait_cyc(4);
      report();
   end
endmodule